// File: doc/BRIEF.md
# Write Replication Requester Controller

This block sits at a compute node and wraps each write aimed at shared remote memory in a two-phase replicated transaction. When the core offers a write, the block takes a free transaction slot, stamps the write with the node's next logical timestamp and works out a fixed set of replica nodes from the line address. It then sends one replicate message to each replica. Each message carries the node's own identifier, the timestamp, the line address and the written data.

Acknowledgments come back on a separate input. They are matched per slot against the replica set and the timestamp. Only when every replica of a slot has acknowledged does the block send a validate message to each replica, with the same timestamp and address. When the last validate message leaves, the core receives a one-cycle completion pulse that carries the timestamp. Several writes may be in flight at once, up to a fixed slot count. All messages share one valid/ready output port.

Top module: `wrep_requester`

## Requirements
- R1: In the cycle after reset is released, `wr_ready` is 1 and both `msg_valid` and `done_valid` are 0.
- R2: Each accepted write produces exactly NUM_REPL replicate messages (`msg_kind`=0), followed later by exactly NUM_REPL validate messages (`msg_kind`=1). Every message has `msg_src`=SELF_ID and carries the write's address and data.
- R3: Replica choice: b = line address bits [NODE_W-1:0] XOR bits [2*NODE_W-1:NODE_W], with NODES a power of two. The replicas are the first NUM_REPL nodes of the walk b, b+1, b+2, … (mod NODES), skipping SELF_ID. Both message phases address the replicas in that walk order.
- R4: The timestamp is 0 for the first write after reset, rises by one for each accepted write, and wraps modulo 2^TS_W. All messages and the completion of a write carry its timestamp.
- R5: No validate message of a write is offered before an acknowledgment has been counted from every one of its replicas. A slot whose acknowledgments are complete starts offering validate messages two cycles after the last acknowledgment is sampled.
- R6: An acknowledgment is counted only if its `ack_ts` equals the slot's timestamp, its `ack_src` is one of that slot's replicas, and the replicate message to that replica has already been accepted. Acknowledgments from other nodes, with another timestamp, repeated, or early have no effect.
- R7: At most SLOTS writes are outstanding. A write is accepted when `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly when every slot is busy, and the lowest-numbered free slot is taken. A slot freed by its last validate message is reusable from the next cycle.
- R8: Among slots with a message to send, the lowest-numbered slot is offered. Once offered with `msg_ready` low, the same message stays on the port with all fields unchanged until it is accepted.
- R9: `done_valid` pulses for one cycle in the cycle after the last validate message of a write is accepted, and `done_ts` carries that write's timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Core offers a write |
| wr_ready | output | 1 | A slot is free; the write is taken this cycle |
| wr_addr | input | ADDR_W | Physical line address of the write |
| wr_data | input | DATA_W | Updated word data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Transport takes the message this cycle |
| msg_kind | output | 1 | 0 = replicate, 1 = validate |
| msg_dest | output | NODE_W | Target replica node |
| msg_src | output | NODE_W | Requesting node identifier (SELF_ID) |
| msg_ts | output | TS_W | Logical timestamp |
| msg_addr | output | ADDR_W | Line address |
| msg_data | output | DATA_W | Word data |
| ack_valid | input | 1 | Acknowledgment present |
| ack_src | input | NODE_W | Node that acknowledges |
| ack_ts | input | TS_W | Timestamp being acknowledged |
| done_valid | output | 1 | Write completion pulse to the core |
| done_ts | output | TS_W | Timestamp of the completed write |

## Verification
The bench builds the block with eight nodes, SELF_ID = 2, three replicas per write, two slots and a 4-bit timestamp. With only two slots, back-pressure and slot reuse occur all the time. The short timestamp wraps every sixteen writes, so wrap-around is exercised many times in one run. With SELF_ID = 2, random addresses often hash onto the requester itself, so the skip-self rule is used constantly. Acknowledgments come back out of order and are mixed with foreign, early, repeated and mis-stamped ones, under a randomly stalling output port.

// File: rtl/wrep_pkg.sv
package wrep_pkg;

    typedef enum logic [1:0] {
        PH_FREE = 2'd0,
        PH_REPL = 2'd1,
        PH_WAIT = 2'd2,
        PH_VAL  = 2'd3
    } wrep_phase_e;

    typedef enum logic {
        KIND_REPL = 1'b0,
        KIND_VAL  = 1'b1
    } wrep_kind_e;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wrep_replica_sel.sv
module wrep_replica_sel
    import wrep_pkg::*;
#(
    parameter int unsigned NODES    = 8,
    parameter int unsigned SELF_ID  = 0,
    parameter int unsigned NUM_REPL = 2,
    parameter int unsigned ADDR_W   = 40,
    localparam int unsigned NODE_W  = $clog2(NODES)
)(
    input  logic [ADDR_W-1:0]                line_addr,
    output logic [NUM_REPL-1:0][NODE_W-1:0] reps
);
    logic [NODE_W-1:0] base;
    logic [NODE_W-1:0] self_off;

    assign base     = line_addr[NODE_W-1:0] ^ line_addr[2*NODE_W-1:NODE_W];
    assign self_off = NODE_W'(SELF_ID) - base;

    // candidate k is base+k; every candidate at or past the requester moves up by one
    for (genvar k = 0; k < NUM_REPL; k++) begin : g_rep
        assign reps[k] = base + NODE_W'(k) + ((self_off <= NODE_W'(k)) ? NODE_W'(1) : NODE_W'(0));
    end
endmodule

// File: rtl/wrep_slot.sv
module wrep_slot
    import wrep_pkg::*;
#(
    parameter int unsigned NODES    = 8,
    parameter int unsigned NUM_REPL = 2,
    parameter int unsigned TS_W     = 8,
    parameter int unsigned ADDR_W   = 40,
    parameter int unsigned DATA_W   = 64,
    localparam int unsigned NODE_W  = $clog2(NODES),
    localparam int unsigned IDX_W   = idx_bits(NUM_REPL)
)(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             alloc,
    input  logic [TS_W-1:0]                  alloc_ts,
    input  logic [ADDR_W-1:0]                alloc_addr,
    input  logic [DATA_W-1:0]                alloc_data,
    input  logic [NUM_REPL-1:0][NODE_W-1:0]  alloc_reps,
    input  logic                             fire,
    input  logic                             ack_valid,
    input  logic [NODE_W-1:0]                ack_src,
    input  logic [TS_W-1:0]                  ack_ts,
    output wrep_phase_e                      phase,
    output logic [IDX_W-1:0]                 idx,
    output logic [TS_W-1:0]                  ts,
    output logic [ADDR_W-1:0]                addr,
    output logic [DATA_W-1:0]                data,
    output logic [NUM_REPL-1:0][NODE_W-1:0]  reps
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REPL - 1);

    logic [NUM_REPL-1:0] mask;
    logic [NUM_REPL-1:0] hit;

    // an acknowledgment counts only for a replica whose replicate message has left
    for (genvar k = 0; k < NUM_REPL; k++) begin : g_hit
        assign hit[k] = ack_valid && (ack_ts == ts) && (ack_src == reps[k]) &&
                        ((phase == PH_WAIT) || ((phase == PH_REPL) && (IDX_W'(k) < idx)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FREE;
            idx   <= '0;
            mask  <= '0;
            ts    <= '0;
            addr  <= '0;
            data  <= '0;
            reps  <= '0;
        end else if (alloc) begin
            phase <= PH_REPL;
            idx   <= '0;
            mask  <= '0;
            ts    <= alloc_ts;
            addr  <= alloc_addr;
            data  <= alloc_data;
            reps  <= alloc_reps;
        end else begin
            unique case (phase)
                PH_REPL: begin
                    mask <= mask | hit;
                    if (fire) begin
                        if (idx == LAST) begin
                            phase <= PH_WAIT;
                            idx   <= '0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                PH_WAIT: begin
                    mask <= mask | hit;
                    if (&mask) phase <= PH_VAL;
                end
                PH_VAL: begin
                    if (fire) begin
                        if (idx == LAST) begin
                            phase <= PH_FREE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wrep_arbiter.sv
module wrep_arbiter
    import wrep_pkg::*;
#(
    parameter int unsigned N = 4,
    localparam int unsigned W = idx_bits(N)
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         take,
    output logic         gnt_any,
    output logic [W-1:0] gnt_idx
);
    logic         locked;
    logic [W-1:0] lock_idx;
    logic         pick_any;
    logic [W-1:0] pick;

    always_comb begin
        pick_any = 1'b0;
        pick     = '0;
        for (int s = N - 1; s >= 0; s--) begin
            if (req[s]) begin
                pick_any = 1'b1;
                pick     = W'(s);
            end
        end
    end

    assign gnt_any = locked | pick_any;
    assign gnt_idx = locked ? lock_idx : pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            lock_idx <= '0;
        end else begin
            locked   <= gnt_any && !take;
            lock_idx <= gnt_idx;
        end
    end
endmodule

// File: rtl/wrep_requester.sv
module wrep_requester
    import wrep_pkg::*;
#(
    parameter int unsigned NODES    = 8,
    parameter int unsigned SELF_ID  = 0,
    parameter int unsigned NUM_REPL = 2,
    parameter int unsigned SLOTS    = 4,
    parameter int unsigned TS_W     = 8,
    parameter int unsigned ADDR_W   = 40,
    parameter int unsigned DATA_W   = 64,
    localparam int unsigned NODE_W  = $clog2(NODES)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic              msg_kind,
    output logic [NODE_W-1:0] msg_dest,
    output logic [NODE_W-1:0] msg_src,
    output logic [TS_W-1:0]   msg_ts,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data,
    input  logic              ack_valid,
    input  logic [NODE_W-1:0] ack_src,
    input  logic [TS_W-1:0]   ack_ts,
    output logic              done_valid,
    output logic [TS_W-1:0]   done_ts
);
    localparam int unsigned SLOT_W = idx_bits(SLOTS);
    localparam int unsigned IDX_W  = idx_bits(NUM_REPL);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REPL - 1);

    typedef logic [NUM_REPL-1:0][NODE_W-1:0] rep_set_t;

    wrep_phase_e       s_phase [SLOTS];
    logic [IDX_W-1:0]  s_idx   [SLOTS];
    logic [TS_W-1:0]   s_ts    [SLOTS];
    logic [ADDR_W-1:0] s_addr  [SLOTS];
    logic [DATA_W-1:0] s_data  [SLOTS];
    rep_set_t          s_reps  [SLOTS];
    logic [SLOTS-1:0]  s_req;

    rep_set_t          new_reps;
    logic [TS_W-1:0]   ts_ctr;
    logic              free_any;
    logic [SLOT_W-1:0] free_idx;
    logic              accept;
    logic              gnt_any;
    logic [SLOT_W-1:0] gnt_idx;
    logic              fire;
    logic              fin;

    wrep_phase_e       g_phase;
    logic [IDX_W-1:0]  g_idx;
    rep_set_t          g_reps;

    wrep_replica_sel #(
        .NODES(NODES), .SELF_ID(SELF_ID), .NUM_REPL(NUM_REPL), .ADDR_W(ADDR_W)
    ) u_sel (
        .line_addr(wr_addr),
        .reps     (new_reps)
    );

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (s_phase[s] == PH_FREE) begin
                free_any = 1'b1;
                free_idx = SLOT_W'(s);
            end
        end
    end

    assign wr_ready = free_any;
    assign accept   = wr_valid && free_any;
    assign fire     = gnt_any && msg_ready;

    always_ff @(posedge clk) begin
        if (rst)         ts_ctr <= '0;
        else if (accept) ts_ctr <= ts_ctr + TS_W'(1);
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign s_req[s] = (s_phase[s] == PH_REPL) || (s_phase[s] == PH_VAL);

        wrep_slot #(
            .NODES(NODES), .NUM_REPL(NUM_REPL), .TS_W(TS_W),
            .ADDR_W(ADDR_W), .DATA_W(DATA_W)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .alloc     (accept && (free_idx == SLOT_W'(s))),
            .alloc_ts  (ts_ctr),
            .alloc_addr(wr_addr),
            .alloc_data(wr_data),
            .alloc_reps(new_reps),
            .fire      (fire && (gnt_idx == SLOT_W'(s))),
            .ack_valid (ack_valid),
            .ack_src   (ack_src),
            .ack_ts    (ack_ts),
            .phase     (s_phase[s]),
            .idx       (s_idx[s]),
            .ts        (s_ts[s]),
            .addr      (s_addr[s]),
            .data      (s_data[s]),
            .reps      (s_reps[s])
        );
    end

    wrep_arbiter #(.N(SLOTS)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .req    (s_req),
        .take   (msg_ready),
        .gnt_any(gnt_any),
        .gnt_idx(gnt_idx)
    );

    always_comb begin
        g_phase  = PH_FREE;
        g_idx    = '0;
        g_reps   = '0;
        msg_ts   = '0;
        msg_addr = '0;
        msg_data = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (gnt_idx == SLOT_W'(s)) begin
                g_phase  = s_phase[s];
                g_idx    = s_idx[s];
                g_reps   = s_reps[s];
                msg_ts   = s_ts[s];
                msg_addr = s_addr[s];
                msg_data = s_data[s];
            end
        end
        msg_dest = '0;
        for (int k = 0; k < NUM_REPL; k++) begin
            if (g_idx == IDX_W'(k)) msg_dest = g_reps[k];
        end
    end

    assign msg_valid = gnt_any;
    assign msg_kind  = (g_phase == PH_VAL) ? KIND_VAL : KIND_REPL;
    assign msg_src   = NODE_W'(SELF_ID);
    assign fin       = fire && (g_phase == PH_VAL) && (g_idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_valid <= 1'b0;
            done_ts    <= '0;
        end else begin
            done_valid <= fin;
            if (fin) done_ts <= msg_ts;
        end
    end
endmodule

// File: rtl/wrep_requester_chk.sv
module wrep_requester_chk #(
    parameter int unsigned SLOTS   = 4,
    parameter int unsigned NODE_W  = 3,
    parameter int unsigned SELF_ID = 0,
    parameter int unsigned TS_W    = 8,
    parameter int unsigned ADDR_W  = 40,
    parameter int unsigned DATA_W  = 64
)(
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic              msg_kind,
    input logic [NODE_W-1:0] msg_dest,
    input logic [TS_W-1:0]   msg_ts,
    input logic [ADDR_W-1:0] msg_addr,
    input logic [DATA_W-1:0] msg_data,
    input logic              done_valid,
    input logic [TS_W-1:0]   done_ts
);
    // writes taken minus completions already reported
    logic [15:0] open_cnt;

    always_ff @(posedge clk) begin
        if (rst) open_cnt <= '0;
        else open_cnt <= open_cnt + 16'(wr_valid && wr_ready) - 16'(done_valid);
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (wr_ready && !msg_valid && !done_valid));

    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_dest) &&
                                       $stable(msg_ts) && $stable(msg_addr) && $stable(msg_data)));

    a_r3_never_self: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_dest != NODE_W'(SELF_ID)));

    a_r9_done_after_val: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> $past(msg_valid && msg_ready && msg_kind));

    a_r9_done_stamp: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_ts == $past(msg_ts)));

    a_r7_full_when_blocked: assert property (@(posedge clk) disable iff (rst)
        !wr_ready |-> ((open_cnt == 16'(SLOTS)) && !done_valid));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        open_cnt <= 16'(SLOTS) + 16'(done_valid));
endmodule

bind wrep_requester wrep_requester_chk #(
    .SLOTS(SLOTS), .NODE_W(NODE_W), .SELF_ID(SELF_ID),
    .TS_W(TS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_kind  (msg_kind),
    .msg_dest  (msg_dest),
    .msg_ts    (msg_ts),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .done_valid(done_valid),
    .done_ts   (done_ts)
);

// File: tb/wrep_requester_tb_top.sv
module wrep_requester_tb_top;
    localparam int NODES    = 8;
    localparam int SELF_ID  = 2;
    localparam int NUM_REPL = 3;
    localparam int SLOTS    = 2;
    localparam int TS_W     = 4;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;
    localparam int NODE_W   = 3;
    localparam int TS_MOD   = 1 << TS_W;
    localparam int FULL     = (1 << NUM_REPL) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              msg_valid;
    logic              msg_ready = 1'b0;
    logic              msg_kind;
    logic [NODE_W-1:0] msg_dest;
    logic [NODE_W-1:0] msg_src;
    logic [TS_W-1:0]   msg_ts;
    logic [ADDR_W-1:0] msg_addr;
    logic [DATA_W-1:0] msg_data;
    logic              ack_valid = 1'b0;
    logic [NODE_W-1:0] ack_src = '0;
    logic [TS_W-1:0]   ack_ts = '0;
    logic              done_valid;
    logic [TS_W-1:0]   done_ts;

    wrep_requester #(
        .NODES(NODES), .SELF_ID(SELF_ID), .NUM_REPL(NUM_REPL), .SLOTS(SLOTS),
        .TS_W(TS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) dut_i (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural reference: 0 free, 1 replicating, 2 waiting, 3 validating
    int     m_ph   [SLOTS];
    int     m_idx  [SLOTS];
    int     m_mask [SLOTS];
    int     m_ts   [SLOTS];
    longint m_addr [SLOTS];
    longint m_data [SLOTS];
    int     m_rep  [SLOTS][NUM_REPL];
    int     m_ctr = 0;
    bit     m_lock = 0;
    int     m_lock_s = 0;
    bit     e_done = 0;
    int     e_done_ts = 0;

    typedef struct { int src; int ts; } ack_t;
    ack_t pend[$];
    ack_t last_ack;
    bit   have_last = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void pick_reps(input longint a, output int r[NUM_REPL]);
        int base = int'(a & 7) ^ int'((a >> 3) & 7);
        int n = base;
        int c = 0;
        while (c < NUM_REPL) begin
            if (n != SELF_ID) begin
                r[c] = n;
                c++;
            end
            n = (n + 1) % NODES;
        end
    endfunction

    function automatic int m_grant();
        if (m_lock) return m_lock_s;
        for (int s = 0; s < SLOTS; s++)
            if (m_ph[s] == 1 || m_ph[s] == 3) return s;
        return -1;
    endfunction

    function automatic int m_free();
        for (int s = 0; s < SLOTS; s++)
            if (m_ph[s] == 0) return s;
        return -1;
    endfunction

    function automatic int m_hits(input int s);
        int h = 0;
        for (int k = 0; k < NUM_REPL; k++)
            if (ack_valid && int'(ack_ts) == m_ts[s] && int'(ack_src) == m_rep[s][k] &&
                (m_ph[s] == 2 || (m_ph[s] == 1 && k < m_idx[s])))
                h |= (1 << k);
        return h;
    endfunction

    task automatic model_step();
        int g = m_grant();
        bit fire = (g >= 0) && msg_ready;
        int fr = m_free();
        bit acc = wr_valid && (fr >= 0);
        int h;
        e_done = fire && m_ph[g] == 3 && m_idx[g] == NUM_REPL - 1;
        if (e_done) e_done_ts = m_ts[g];
        if (fire && m_ph[g] == 1) pend.push_back('{m_rep[g][m_idx[g]], m_ts[g]});
        m_lock = (g >= 0) && !msg_ready;
        m_lock_s = g;
        for (int s = 0; s < SLOTS; s++) begin
            h = m_hits(s);
            if (acc && s == fr) begin
                int r[NUM_REPL];
                pick_reps(longint'(wr_addr), r);
                m_ph[s] = 1; m_idx[s] = 0; m_mask[s] = 0; m_ts[s] = m_ctr;
                m_addr[s] = longint'(wr_addr); m_data[s] = longint'(wr_data);
                for (int k = 0; k < NUM_REPL; k++) m_rep[s][k] = r[k];
            end else if (m_ph[s] == 1) begin
                m_mask[s] |= h;
                if (fire && g == s) begin
                    if (m_idx[s] == NUM_REPL - 1) begin m_ph[s] = 2; m_idx[s] = 0; end
                    else m_idx[s]++;
                end
            end else if (m_ph[s] == 2) begin
                if (m_mask[s] == FULL) m_ph[s] = 3;
                m_mask[s] |= h;
            end else if (m_ph[s] == 3) begin
                if (fire && g == s) begin
                    if (m_idx[s] == NUM_REPL - 1) begin m_ph[s] = 0; m_idx[s] = 0; end
                    else m_idx[s]++;
                end
            end
        end
        if (acc) m_ctr = (m_ctr + 1) % TS_MOD;
    endtask

    task automatic compare_all();
        int g = m_grant();
        chk(wr_ready == (m_free() >= 0), "R7", "wr_ready", wr_ready, m_free() >= 0);
        chk(msg_valid == (g >= 0), "R5", "msg_valid", msg_valid, g >= 0);
        if (g >= 0 && msg_valid) begin
            chk(msg_kind == (m_ph[g] == 3), "R2", "msg_kind", msg_kind, m_ph[g] == 3);
            chk(int'(msg_dest) == m_rep[g][m_idx[g]], "R3", "msg_dest", msg_dest, m_rep[g][m_idx[g]]);
            chk(int'(msg_src) == SELF_ID, "R2", "msg_src", msg_src, SELF_ID);
            chk(int'(msg_ts) == m_ts[g], "R4", "msg_ts (order per R8)", msg_ts, m_ts[g]);
            chk(longint'(msg_addr) == m_addr[g], "R2", "msg_addr", msg_addr, m_addr[g]);
            chk(longint'(msg_data) == m_data[g], "R2", "msg_data", msg_data, m_data[g]);
        end
        chk(done_valid == e_done, "R9", "done_valid", done_valid, e_done);
        if (e_done && done_valid)
            chk(int'(done_ts) == e_done_ts, "R9", "done_ts", done_ts, e_done_ts);
    endtask

    task automatic step_cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    // junk acknowledgments that R6 says must be ignored (or that the reference treats alike)
    task automatic drive_junk();
        int kind = int'($urandom % 4);
        ack_valid = 1'b1;
        ack_src = NODE_W'(SELF_ID);
        ack_ts = TS_W'(m_ts[0]);
        if (kind == 1 && pend.size() > 0) begin
            ack_src = NODE_W'(pend[0].src);
            ack_ts = TS_W'((pend[0].ts + 8) % TS_MOD);
        end else if (kind == 2 && have_last) begin
            ack_src = NODE_W'(last_ack.src);
            ack_ts = TS_W'(last_ack.ts);
        end else if (kind == 3) begin
            for (int s = 0; s < SLOTS; s++)
                if (m_ph[s] == 1) begin
                    ack_src = NODE_W'(m_rep[s][m_idx[s]]);
                    ack_ts = TS_W'(m_ts[s]);
                end
        end
    endtask

    task automatic drive(input int wr_pct, input int rdy_pct, input bit acks_on, input bit junk_on);
        wr_valid = (($urandom % 100) < wr_pct);
        wr_addr = ADDR_W'($urandom);
        wr_data = DATA_W'($urandom);
        msg_ready = (($urandom % 100) < rdy_pct);
        ack_valid = 1'b0;
        if (junk_on && ($urandom % 4) == 0) begin
            drive_junk();
        end else if (acks_on && pend.size() > 0 && ($urandom % 2) == 1) begin
            int i = int'($urandom % pend.size());
            ack_t a = pend[i];
            pend.delete(i);
            ack_valid = 1'b1;
            ack_src = NODE_W'(a.src);
            ack_ts = TS_W'(a.ts);
            last_ack = a;
            have_last = 1;
        end
    endtask

    function automatic bit model_idle();
        for (int s = 0; s < SLOTS; s++) if (m_ph[s] != 0) return 0;
        return pend.size() == 0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=expired expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SLOTS; s++) begin
            m_ph[s] = 0; m_idx[s] = 0; m_mask[s] = 0; m_ts[s] = 0;
            m_addr[s] = 0; m_data[s] = 0;
            for (int k = 0; k < NUM_REPL; k++) m_rep[s][k] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);
        chk(msg_valid == 1'b0, "R1", "msg_valid after reset", msg_valid, 0);
        chk(done_valid == 1'b0, "R1", "done_valid after reset", done_valid, 0);

        // R3: hash lands on the requester itself (base 2): replicas 3,4,5
        wr_valid = 1'b1; wr_addr = 16'h0002; wr_data = 32'hA5A5_0001;
        msg_ready = 1'b1; ack_valid = 1'b0;
        step_cycle();
        wr_valid = 1'b0;
        for (int c = 0; c < 8; c++) begin
            drive(0, 100, 0, 0);
            step_cycle();
        end
        // R5: all replicates sent, no acks yet -> nothing offered
        chk(msg_valid == 1'b0, "R5", "no validate without acks", msg_valid, 0);
        for (int c = 0; c < 12; c++) begin
            drive(0, 100, 0, 1);
            step_cycle();
        end
        chk(msg_valid == 1'b0, "R6", "junk acks ignored", msg_valid, 0);
        chk(wr_ready == 1'b1, "R7", "one slot still free", wr_ready, 1);

        // R3: base 7 wraps to 7,0,1; fills the second slot
        wr_valid = 1'b1; wr_addr = 16'h0038; wr_data = 32'h5A5A_0002;
        msg_ready = 1'b0; ack_valid = 1'b0;
        step_cycle();
        chk(wr_ready == 1'b0, "R7", "back-pressure when full", wr_ready, 0);
        for (int c = 0; c < 4; c++) begin
            drive(100, 0, 0, 0);
            step_cycle();
        end
        chk(msg_valid == 1'b1, "R8", "stalled replicate held", msg_valid, 1);

        for (int c = 0; c < 60; c++) begin
            drive(0, 100, 1, 0);
            step_cycle();
        end

        // random phases, with timestamp wrap, stalls and junk
        for (int c = 0; c < 1500; c++) begin
            drive(40, 70, 1, 1);
            step_cycle();
        end
        for (int c = 0; c < 1500; c++) begin
            drive(90, 30, 1, 1);
            step_cycle();
        end
        for (int c = 0; c < 1000; c++) begin
            drive(100, 100, 1, 0);
            step_cycle();
        end

        // drain
        for (int c = 0; c < 1000 && !model_idle(); c++) begin
            drive(0, 100, 1, 0);
            step_cycle();
        end
        chk(model_idle(), "R2", "all writes completed", !model_idle(), 0);
        chk(wr_ready == 1'b1, "R7", "slots free after drain", wr_ready, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule